// File: doc/BRIEF.md
# UART control and status core

An 8-bit asynchronous serial transceiver behind a small word-addressed register port. Software programs a 16-bit clock divisor, a parity type and a channel route. It then turns the receiver and the transmitter on and off with strobes written to a command register. Characters go out through a one-entry holding register in front of a shift register. Incoming characters land in a receive holding register. Ready and empty flags and three sticky error flags can be read at any time, and any of these status bits can be routed to a single level interrupt through a mask.

The register port has no back-pressure. A write or read strobe is accepted in the cycle it is presented, and `rdata` follows `addr` combinationally. Reading the data address in a cycle with `rd_en` high counts as consuming the received character. The serial side has no flow control: the core offers the transmit holding register and shows with status whether it has room, and a received character that finds the previous one unread overwrites it and raises the overrun flag.

Top module: `uart_core`

## Requirements
- R1: After reset the status word (address 6) and the interrupt mask (address 5) read 0, `irq` is low, `txd` is high, and both directions are off.
- R2: A transmitted frame is a low start bit, 8 data bits LSB first, an optional parity bit and a high stop bit, each lasting 16 x divisor clocks (divisor at address 2). Mode bits [1:0] (address 1) select the parity: 1 gives even parity, 2 gives odd parity, and 0 or 3 sends no parity bit.
- R3: The receiver samples every bit at mid-bit on a 16x oversampled clock. A complete character goes to the data register (address 7, read) and sets status bit 0. A read of address 7 clears that bit.
- R4: Command register (address 0) bits: 0 receiver reset, 1 transmitter reset, 2 receiver enable, 3 receiver disable, 4 transmitter enable, 5 transmitter disable, 6 error clear. An enable takes effect only when the matching disable bit is 0 in the same write, so the disable wins.
- R5: A transmitter disable lets the character in the shift register and the character waiting in the holding register both go out before the transmitter stops. Writes to address 7 while the transmitter is off are discarded.
- R6: A receiver disable written while a character is arriving lets that character complete into the data register before the receiver stops. While the receiver is off, status bit 0 reads 0.
- R7: A reset strobe stops its direction at once. A transmitter reset returns `txd` high on the next cycle and discards any held character. A receiver reset drops the partial character and leaves the data register unchanged.
- R8: Status bit 1 (transmit ready) is 1 when the transmitter is on and the holding register is free. Status bit 2 (transmit empty) is 1 when the transmitter is on and both the holding and the shift registers are idle. Both read 0 while the transmitter is off.
- R9: Status bit 3 (overrun: a character arrives while bit 0 is still set), bit 4 (framing: stop bit sampled low) and bit 5 (parity mismatch) are sticky. Only command bit 6 clears them, all three together.
- R10: A write of 1s to address 3 sets mask bits and a write of 1s to address 4 clears them, each without touching the other bits. Address 5 reads the mask, and `irq` is high when any status bit is set together with its mask bit.
- R11: Mode bits [5:4] select the route. 0 is normal. 1 is echo: `txd` follows `rxd` and the receiver still hears `rxd`. 2 is local loopback: the receiver hears the transmitter and `txd` stays high. 3 is remote loopback: `txd` follows `rxd` and the receiver hears an idle line.
- R12: A divisor of 0 stops the baud clock, so a frame in progress freezes on its current bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect only at address 7) |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Level interrupt |

## Verification
Some properties are checked on every cycle: the ordering of the transmit flags (empty implies ready), that error flags hold until a clear command, that the interrupt stays quiet under an empty mask, that `txd` follows the selected route in echo, local and remote modes, that the line returns high after a transmitter reset, and that a zero divisor produces no baud tick. The effects that take whole frames only show up in the bench scenarios: bit timing and parity on the wire, a graceful stop that lets in-flight characters finish, overrun ordering, and characters arriving through loopback.

// File: rtl/uart_core_pkg.sv
package uart_core_pkg;

  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chan_e;

  // register word addresses
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_MODE  = 3'd1;
  localparam logic [2:0] A_DIV   = 3'd2;
  localparam logic [2:0] A_IEN   = 3'd3;
  localparam logic [2:0] A_IDIS  = 3'd4;
  localparam logic [2:0] A_IMASK = 3'd5;
  localparam logic [2:0] A_STAT  = 3'd6;
  localparam logic [2:0] A_DATA  = 3'd7;

  // command strobe bit positions
  localparam int C_RXRST  = 0;
  localparam int C_TXRST  = 1;
  localparam int C_RXEN   = 2;
  localparam int C_RXDIS  = 3;
  localparam int C_TXEN   = 4;
  localparam int C_TXDIS  = 5;
  localparam int C_CLRERR = 6;

  // status bit positions
  localparam int S_RXRDY   = 0;
  localparam int S_TXRDY   = 1;
  localparam int S_TXEMPTY = 2;
  localparam int S_OVR     = 3;
  localparam int S_FRM     = 4;
  localparam int S_PAR     = 5;
  localparam int ST_W      = 6;

endpackage

// File: rtl/uart_core_baud.sv
module uart_core_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_core_tx.sv
module uart_core_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              abort,
  input  logic              run,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [1:0]        par_mode,
  output logic              line,
  output logic              thr_full,
  output logic              busy
);

  localparam int FR_W  = DATA_W + 3;
  localparam int CNT_W = $clog2(FR_W + 1);
  localparam int SUB_W = $clog2(OVS);

  logic [DATA_W-1:0] hold;
  logic [FR_W-1:0]   sh;
  logic [CNT_W-1:0]  left;
  logic [SUB_W-1:0]  sub;
  logic              par_en, par_val;
  logic [FR_W-1:0]   frame;
  logic [CNT_W-1:0]  nbits;

  always_comb begin
    par_en  = par_mode[0] ^ par_mode[1];
    par_val = par_mode[1] ? ~^hold : ^hold;
    frame   = {1'b1, (par_en ? par_val : 1'b1), hold, 1'b0};
    nbits   = par_en ? CNT_W'(FR_W) : CNT_W'(FR_W - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= '0;
      sh       <= '1;
      left     <= '0;
      sub      <= '0;
      thr_full <= 1'b0;
      busy     <= 1'b0;
    end else if (abort) begin
      thr_full <= 1'b0;
      busy     <= 1'b0;
      sub      <= '0;
    end else begin
      if (!busy && thr_full && run) begin
        sh       <= frame;
        left     <= nbits;
        sub      <= '0;
        busy     <= 1'b1;
        thr_full <= 1'b0;
      end else if (busy && tick) begin
        if (sub == SUB_W'(OVS - 1)) begin
          sub  <= '0;
          sh   <= {1'b1, sh[FR_W-1:1]};
          left <= left - 1'b1;
          if (left == CNT_W'(1)) busy <= 1'b0;
        end else begin
          sub <= sub + 1'b1;
        end
      end
      if (ld) begin
        hold     <= ld_data;
        thr_full <= 1'b1;
      end
    end
  end

  assign line = busy ? sh[0] : 1'b1;

endmodule

// File: rtl/uart_core_rx.sv
module uart_core_rx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              abort,
  input  logic              arm,
  input  logic              line_in,
  input  logic [1:0]        par_mode,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              frm_err,
  output logic              par_err
);

  localparam int CNT_W = $clog2(DATA_W + 3);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] MID = SUB_W'(OVS / 2 - 1);

  logic             s1, s2;
  logic [SUB_W-1:0] sub;
  logic [CNT_W-1:0] idx, last_idx;
  logic             par_en, par_seen, par_exp, need_high;

  always_comb begin
    par_en   = par_mode[0] ^ par_mode[1];
    par_exp  = par_mode[1] ? ~^data : ^data;
    last_idx = par_en ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      data      <= '0;
      frm_err   <= 1'b0;
      par_err   <= 1'b0;
      sub       <= '0;
      idx       <= '0;
      par_seen  <= 1'b0;
      need_high <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy      <= 1'b0;
        need_high <= 1'b0;
      end else begin
        if (need_high && s2) need_high <= 1'b0;
        if (!busy) begin
          if (arm && !s2 && !need_high) begin
            busy <= 1'b1;
            sub  <= '0;
            idx  <= '0;
          end
        end else if (tick) begin
          sub <= sub + 1'b1;
          if (sub == MID) begin
            if (idx == '0) begin
              if (s2) busy <= 1'b0;
              else    idx  <= CNT_W'(1);
            end else if (idx <= CNT_W'(DATA_W)) begin
              data <= {s2, data[DATA_W-1:1]};
              idx  <= idx + 1'b1;
            end else if (idx == last_idx) begin
              busy    <= 1'b0;
              done    <= 1'b1;
              frm_err <= !s2;
              par_err <= par_en && (par_seen != par_exp);
              if (!s2) need_high <= 1'b1;
            end else begin
              par_seen <= s2;
              idx      <= idx + 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/uart_core.sv
module uart_core
  import uart_core_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 3,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq
);

  logic wr_ctrl, wr_mode, wr_div, wr_ien, wr_idis, wr_data, rd_data;

  always_comb begin
    wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
    wr_mode = wr_en && (addr == ADDR_W'(A_MODE));
    wr_div  = wr_en && (addr == ADDR_W'(A_DIV));
    wr_ien  = wr_en && (addr == ADDR_W'(A_IEN));
    wr_idis = wr_en && (addr == ADDR_W'(A_IDIS));
    wr_data = wr_en && (addr == ADDR_W'(A_DATA));
    rd_data = rd_en && (addr == ADDR_W'(A_DATA));
  end

  logic tx_rst_cmd, rx_rst_cmd, clr_cmd;
  assign tx_rst_cmd = wr_ctrl && wdata[C_TXRST];
  assign rx_rst_cmd = wr_ctrl && wdata[C_RXRST];
  assign clr_cmd    = wr_ctrl && wdata[C_CLRERR];

  // configuration
  logic [1:0]       par_mode_q;
  chan_e            chan_q;
  logic [DIV_W-1:0] div_q;
  logic [ST_W-1:0]  mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_mode_q <= 2'd0;
      chan_q     <= CH_NORMAL;
      div_q      <= '0;
      mask_q     <= '0;
    end else begin
      if (wr_mode) begin
        par_mode_q <= wdata[1:0];
        chan_q     <= chan_e'(wdata[5:4]);
      end
      if (wr_div)  div_q  <= wdata[DIV_W-1:0];
      if (wr_ien)  mask_q <= mask_q | wdata[ST_W-1:0];
      if (wr_idis) mask_q <= mask_q & ~wdata[ST_W-1:0];
    end
  end

  // baud tick
  logic tick;
  uart_core_baud #(.DIV_W(DIV_W)) u_baud (
    .clk (clk),
    .rst_n(rst_n),
    .div (div_q),
    .tick(tick)
  );

  // direction enables with graceful stop
  logic tx_on, tx_pend, rx_on, rx_pend;
  logic tx_busy, tx_full, tx_line;
  logic rx_busy, rx_done, rx_frm, rx_par, rx_line;
  logic [DATA_W-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_on   <= 1'b0;
      tx_pend <= 1'b0;
    end else if (tx_rst_cmd) begin
      tx_on   <= 1'b0;
      tx_pend <= 1'b0;
    end else if (wr_ctrl && wdata[C_TXDIS]) begin
      tx_pend <= tx_on;
    end else if (wr_ctrl && wdata[C_TXEN]) begin
      tx_on   <= 1'b1;
      tx_pend <= 1'b0;
    end else if (tx_pend && !tx_busy && !tx_full) begin
      tx_on   <= 1'b0;
      tx_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_on   <= 1'b0;
      rx_pend <= 1'b0;
    end else if (rx_rst_cmd) begin
      rx_on   <= 1'b0;
      rx_pend <= 1'b0;
    end else if (wr_ctrl && wdata[C_RXDIS]) begin
      rx_pend <= rx_on;
    end else if (wr_ctrl && wdata[C_RXEN]) begin
      rx_on   <= 1'b1;
      rx_pend <= 1'b0;
    end else if (rx_pend && !rx_busy) begin
      rx_on   <= 1'b0;
      rx_pend <= 1'b0;
    end
  end

  uart_core_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .abort   (tx_rst_cmd),
    .run     (tx_on),
    .ld      (wr_data && tx_on),
    .ld_data (wdata[DATA_W-1:0]),
    .par_mode(par_mode_q),
    .line    (tx_line),
    .thr_full(tx_full),
    .busy    (tx_busy)
  );

  uart_core_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .abort   (rx_rst_cmd),
    .arm     (rx_on && !rx_pend),
    .line_in (rx_line),
    .par_mode(par_mode_q),
    .busy    (rx_busy),
    .done    (rx_done),
    .data    (rx_byte),
    .frm_err (rx_frm),
    .par_err (rx_par)
  );

  // channel routing
  always_comb begin
    unique case (chan_q)
      CH_ECHO:   begin rx_line = rxd;     txd = rxd;     end
      CH_LOCAL:  begin rx_line = tx_line; txd = 1'b1;    end
      CH_REMOTE: begin rx_line = 1'b1;    txd = rxd;     end
      default:   begin rx_line = rxd;     txd = tx_line; end
    endcase
  end

  // receive holding register and sticky flags
  logic [DATA_W-1:0] rhr_q;
  logic rxrdy_q, ovr_q, frm_q, par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rhr_q   <= '0;
      rxrdy_q <= 1'b0;
      ovr_q   <= 1'b0;
      frm_q   <= 1'b0;
      par_q   <= 1'b0;
    end else begin
      if (rx_done) rhr_q <= rx_byte;
      if (!rx_on)       rxrdy_q <= 1'b0;
      else if (rx_done) rxrdy_q <= 1'b1;
      else if (rd_data) rxrdy_q <= 1'b0;
      if (clr_cmd) begin
        ovr_q <= 1'b0;
        frm_q <= 1'b0;
        par_q <= 1'b0;
      end
      if (rx_done && rxrdy_q) ovr_q <= 1'b1;
      if (rx_done && rx_frm)  frm_q <= 1'b1;
      if (rx_done && rx_par)  par_q <= 1'b1;
    end
  end

  logic [ST_W-1:0] status;
  always_comb begin
    status            = '0;
    status[S_RXRDY]   = rxrdy_q;
    status[S_TXRDY]   = tx_on && !tx_full;
    status[S_TXEMPTY] = tx_on && !tx_full && !tx_busy;
    status[S_OVR]     = ovr_q;
    status[S_FRM]     = frm_q;
    status[S_PAR]     = par_q;
  end

  assign irq = |(status & mask_q);

  always_comb begin
    unique case (addr)
      ADDR_W'(A_MODE):  rdata = BUS_W'({chan_q, 2'b00, par_mode_q});
      ADDR_W'(A_DIV):   rdata = BUS_W'(div_q);
      ADDR_W'(A_IMASK): rdata = BUS_W'(mask_q);
      ADDR_W'(A_STAT):  rdata = BUS_W'(status);
      ADDR_W'(A_DATA):  rdata = BUS_W'(rhr_q);
      default:          rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_core_chk.sv
module uart_core_chk
  import uart_core_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  wdata,
  input logic              rxd,
  input logic              txd,
  input logic              irq,
  input logic [DIV_W-1:0]  div_q,
  input logic              tick,
  input logic [1:0]        chan,
  input logic [ST_W-1:0]   mask,
  input logic [ST_W-1:0]   status
);

  logic ctrl_wr, clr_wr, txrst_wr;
  assign ctrl_wr  = wr_en && (addr == ADDR_W'(A_CTRL));
  assign clr_wr   = ctrl_wr && wdata[C_CLRERR];
  assign txrst_wr = ctrl_wr && wdata[C_TXRST];

  AST_EMPTY_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    status[S_TXEMPTY] |-> status[S_TXRDY]); // R8

  AST_FRM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[S_FRM] && !clr_wr) |=> status[S_FRM]); // R9

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[S_OVR] && !clr_wr) |=> status[S_OVR]); // R9

  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[S_PAR] && !clr_wr) |=> status[S_PAR]); // R9

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R10

  AST_LOCAL_TXD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (chan == 2'd2) |-> txd); // R11

  AST_MIRROR_TXD: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan == 2'd1) || (chan == 2'd3)) |-> (txd == rxd)); // R11

  AST_TXRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (txrst_wr && chan == 2'd0) |=> txd); // R7

  AST_DIV0_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |=> !tick); // R12

endmodule

bind uart_core uart_core_chk #(
  .DIV_W (DIV_W),
  .BUS_W (BUS_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .rxd   (rxd),
  .txd   (txd),
  .irq   (irq),
  .div_q (div_q),
  .tick  (tick),
  .chan  (chan_q),
  .mask  (mask_q),
  .status(status)
);

// File: tb/tb_uart_core.sv
module tb_uart_core;
  import uart_core_pkg::*;

  localparam int CLK_NS = 10;
  localparam int DIVV   = 2;
  localparam int BITC   = 16 * DIVV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rxd = 1'b1;
  logic        txd;
  logic        irq;

  uart_core dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_chan = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] a, input logic [15:0] e);
    logic [15:0] d;
    rd(a, d);
    check(tag, {16'h0, d}, {16'h0, e});
  endtask

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (BITC) @(negedge clk);
  endtask

  // behavioural line driver: start, data LSB first, optional parity, stop
  task automatic send_rx(input logic [7:0] b, input int pm, input bit bad_par, input bit bad_stop);
    @(negedge clk);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(b[i]);
    if (pm == 1) hold_bit((^b) ^ bad_par);
    if (pm == 2) hold_bit((~^b) ^ bad_par);
    hold_bit(!bad_stop);
    rxd = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  // behavioural line decoder on txd
  task automatic grab_tx(input int pm, output logic [7:0] b, output logic pb, output logic sb);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (BITC / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (BITC) @(negedge clk);
      b[i] = txd;
    end
    pb = 1'b0;
    if (pm == 1 || pm == 2) begin
      repeat (BITC) @(negedge clk);
      pb = txd;
    end
    repeat (BITC) @(negedge clk);
    sb = txd;
  endtask

  // per-clock reference on routed line
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (exp_chan == 1 || exp_chan == 3) check("R11 txd mirrors rxd", {31'h0, txd}, {31'h0, rxd});
      else if (exp_chan == 2) check("R11 txd idle in local loopback", {31'h0, txd}, 32'h1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0]  b, b2;
    logic        pb, sb, pb2, sb2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_reg("R1 status after reset", A_STAT, 16'h0000);
    expect_reg("R1 mask after reset", A_IMASK, 16'h0000);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    check("R1 txd idle after reset", {31'h0, txd}, 32'h1);

    wr(A_DIV, 16'(DIVV));
    wr(A_CTRL, 16'h0014);
    expect_reg("R8 ready and empty once enabled", A_STAT, 16'h0006);

    // R2 frame without parity
    fork
      grab_tx(0, b, pb, sb);
      begin
        wr(A_DATA, 16'h00A5);
        repeat (4) @(negedge clk);
        expect_reg("R8 ready not empty while shifting", A_STAT, 16'h0002);
      end
    join
    check("R2 data no parity", {24'h0, b}, 32'hA5);
    check("R2 stop bit", {31'h0, sb}, 32'h1);
    repeat (BITC) @(negedge clk);
    expect_reg("R8 empty after frame", A_STAT, 16'h0006);

    // R2 even and odd parity
    wr(A_MODE, 16'h0001);
    fork grab_tx(1, b, pb, sb); wr(A_DATA, 16'h0037); join
    check("R2 even data", {24'h0, b}, 32'h37);
    check("R2 even parity bit", {31'h0, pb}, 32'h1);
    repeat (BITC) @(negedge clk);
    wr(A_MODE, 16'h0002);
    fork grab_tx(2, b, pb, sb); wr(A_DATA, 16'h0037); join
    check("R2 odd parity bit", {31'h0, pb}, 32'h0);
    check("R2 odd stop", {31'h0, sb}, 32'h1);
    repeat (BITC) @(negedge clk);
    wr(A_MODE, 16'h0000);

    // R3 reception
    send_rx(8'h5C, 0, 0, 0);
    expect_reg("R3 ready after character", A_STAT, 16'h0007);
    expect_reg("R3 received data", A_DATA, 16'h005C);
    expect_reg("R3 ready cleared by read", A_STAT, 16'h0006);

    // R9 framing, sticky
    send_rx(8'h11, 0, 0, 1);
    expect_reg("R9 framing flag", A_STAT, 16'h0017);
    expect_reg("R9 data with bad stop", A_DATA, 16'h0011);
    send_rx(8'h22, 0, 0, 0);
    expect_reg("R9 framing stays set", A_STAT, 16'h0017);
    expect_reg("R3 next data", A_DATA, 16'h0022);

    // R9 overrun
    send_rx(8'h33, 0, 0, 0);
    send_rx(8'h44, 0, 0, 0);
    expect_reg("R9 overrun flag", A_STAT, 16'h001F);
    expect_reg("R9 overrun keeps newest", A_DATA, 16'h0044);
    wr(A_CTRL, 16'h0040);
    expect_reg("R9 clear wipes all three", A_STAT, 16'h0006);

    // R9 parity error
    wr(A_MODE, 16'h0001);
    send_rx(8'h37, 1, 1, 0);
    expect_reg("R9 parity flag", A_STAT, 16'h0027);
    expect_reg("R9 parity data", A_DATA, 16'h0037);
    wr(A_CTRL, 16'h0040);
    send_rx(8'h55, 1, 0, 0);
    expect_reg("R9 good even parity no flag", A_STAT, 16'h0007);
    expect_reg("R3 even parity data", A_DATA, 16'h0055);
    wr(A_MODE, 16'h0000);

    // R10 interrupt mask
    wr(A_IEN, 16'h0001);
    expect_reg("R10 mask set", A_IMASK, 16'h0001);
    check("R10 irq low with no ready", {31'h0, irq}, 32'h0);
    send_rx(8'h66, 0, 0, 0);
    check("R10 irq on ready", {31'h0, irq}, 32'h1);
    expect_reg("R10 data", A_DATA, 16'h0066);
    check("R10 irq falls after read", {31'h0, irq}, 32'h0);
    wr(A_IEN, 16'h0004);
    expect_reg("R10 enable keeps other bits", A_IMASK, 16'h0005);
    check("R10 irq on tx empty", {31'h0, irq}, 32'h1);
    wr(A_IDIS, 16'h0004);
    expect_reg("R10 disable clears one bit", A_IMASK, 16'h0001);
    check("R10 irq low after disable", {31'h0, irq}, 32'h0);
    wr(A_IDIS, 16'h0001);

    // R4 disable wins
    wr(A_CTRL, 16'h0030);
    expect_reg("R4 disable beats enable", A_STAT, 16'h0000);
    wr(A_CTRL, 16'h0010);
    expect_reg("R4 enable alone", A_STAT, 16'h0006);

    // R5 graceful transmitter stop
    fork
      begin grab_tx(0, b, pb, sb); grab_tx(0, b2, pb2, sb2); end
      begin wr(A_DATA, 16'h00A1); wr(A_DATA, 16'h00B2); wr(A_CTRL, 16'h0020); end
    join
    check("R5 shifting char completes", {24'h0, b}, 32'hA1);
    check("R5 held char completes", {24'h0, b2}, 32'hB2);
    repeat (BITC) @(negedge clk);
    expect_reg("R8 not ready when off", A_STAT, 16'h0000);
    wr(A_DATA, 16'h0077);
    repeat (2 * BITC) @(negedge clk);
    check("R5 write while off not sent", {31'h0, txd}, 32'h1);
    wr(A_CTRL, 16'h0010);
    expect_reg("R5 write while off discarded", A_STAT, 16'h0006);

    // R7 transmitter reset aborts
    wr(A_DATA, 16'h0000);
    repeat (3 * BITC) @(negedge clk);
    check("R7 line busy before reset", {31'h0, txd}, 32'h0);
    wr(A_CTRL, 16'h0002);
    check("R7 line high after reset", {31'h0, txd}, 32'h1);
    repeat (2 * BITC) @(negedge clk);
    check("R7 line stays high", {31'h0, txd}, 32'h1);
    expect_reg("R7 transmitter off", A_STAT, 16'h0000);
    wr(A_CTRL, 16'h0010);
    expect_reg("R7 nothing left pending", A_STAT, 16'h0006);

    // R7 receiver reset aborts
    fork
      send_rx(8'h99, 0, 0, 0);
      begin repeat (4 * BITC) @(negedge clk); wr(A_CTRL, 16'h0001); end
    join
    expect_reg("R7 data register unchanged", A_DATA, 16'h0066);
    expect_reg("R7 no ready after rx reset", A_STAT, 16'h0006);
    wr(A_CTRL, 16'h0004);

    // R6 graceful receiver stop
    fork
      send_rx(8'hC3, 0, 0, 0);
      begin repeat (4 * BITC) @(negedge clk); wr(A_CTRL, 16'h0008); end
    join
    expect_reg("R6 character completed", A_DATA, 16'h00C3);
    expect_reg("R6 ready reads 0 when off", A_STAT, 16'h0006);
    wr(A_CTRL, 16'h0004);

    // R11 local loopback
    wr(A_MODE, 16'h0020); exp_chan = 2;
    wr(A_DATA, 16'h003C);
    repeat (12 * BITC) @(negedge clk);
    expect_reg("R11 local loopback ready", A_STAT, 16'h0007);
    expect_reg("R11 local loopback data", A_DATA, 16'h003C);
    wr(A_MODE, 16'h0000); exp_chan = 0;

    // R11 echo
    wr(A_MODE, 16'h0010); exp_chan = 1;
    send_rx(8'h96, 0, 0, 0);
    expect_reg("R11 echo receiver hears line", A_DATA, 16'h0096);

    // R11 remote loopback
    wr(A_MODE, 16'h0030); exp_chan = 3;
    send_rx(8'h69, 0, 0, 0);
    expect_reg("R11 remote loopback receiver idle", A_STAT, 16'h0006);
    wr(A_MODE, 16'h0000); exp_chan = 0;

    // R12 divisor zero freezes
    wr(A_DIV, 16'h0000);
    wr(A_DATA, 16'h0081);
    repeat (200) @(negedge clk);
    check("R12 start bit frozen", {31'h0, txd}, 32'h0);
    expect_reg("R12 frame not finishing", A_STAT, 16'h0002);
    repeat (200) @(negedge clk);
    check("R12 still frozen", {31'h0, txd}, 32'h0);
    wr(A_CTRL, 16'h0002);
    wr(A_DIV, 16'(DIVV));
    wr(A_CTRL, 16'h0010);
    expect_reg("R12 recovered", A_STAT, 16'h0006);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule